// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Transmitter

This block sends a packet of bytes over a single open-drain wire. The line is never driven high. The block asserts an output enable, `line_oe`, that turns on a driver tied to zero. When the enable is low the line is released and a pull-up outside the block takes it high. Each bit is one low pulse followed by one released period. The lengths of the two parts carry the bit value. A zero has a long low and a short high. A one has a short low and a long high. Once the last byte has been sent, a short low pulse marks the stop and the line is released.

Bytes enter through a valid/ready handshake. Each beat carries a last-byte flag and a void flag. The void flag lets a caller ask for an empty packet, which puts nothing on the wire. The block holds one byte in reserve. It offers `in_ready` only while the final bit of the current byte is on the wire, so a caller that answers at once gets back-to-back bits with no gap. Two timing sets exist, chosen by `slow_mode` when the packet starts. The nominal set gives zero = 3 µs low / 1 µs high and one = 1 µs low / 3 µs high, at 16 clock cycles per µs. The relaxed set stretches a zero to 4 µs low / 1.5 µs high, for devices that reject the nominal timing.

Top module: `pulse_wire_tx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `line_oe`, `busy` and `done` are 0 and `in_ready` is 1.
- R2: In nominal mode (`slow_mode`=0) a 0 bit is exactly 48 cycles with `line_oe`=1 followed by exactly 16 cycles with `line_oe`=0.
- R3: In either mode a 1 bit is exactly 16 cycles with `line_oe`=1 followed by exactly 48 cycles with `line_oe`=0.
- R4: In relaxed mode (`slow_mode`=1) a 0 bit is exactly 64 cycles with `line_oe`=1 followed by exactly 24 cycles with `line_oe`=0.
- R5: Each byte is sent bit 7 first and bit 0 last. Bytes go out in the order they were accepted, and each bit's low pulse starts in the cycle right after the previous bit's released period ends.
- R6: When the first byte of a packet is accepted at a clock edge, `line_oe` and `busy` are both 1 in the cycle that follows that edge.
- R7: After the released period of the last bit of the byte flagged `in_last`, `line_oe` is 1 for exactly 16 cycles (the stop bit) and then returns to 0. A packet of N bytes therefore shows exactly 8N+1 low pulses.
- R8: `done` is 1 for exactly one cycle per packet, and that cycle is the first one in which both `busy` and `line_oe` are 0 after the stop bit.
- R9: During a packet, `in_ready` is 1 only while the last bit (bit 0) of a byte that is not flagged last is on the wire and no byte is held in reserve. A byte accepted in that window follows with no gap.
- R10: A beat with `in_valid`=1 and `in_void`=1 accepted while idle produces no low pulse and leaves `busy` at 0. `done` pulses in the cycle that follows the accepting edge.
- R11: `slow_mode` is sampled when the first byte is accepted. Changing it later in the packet has no effect on that packet's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_mode | input | 1 | 1 selects the relaxed timing for a 0 bit; sampled at packet start |
| in_valid | input | 1 | A byte (or void request) is offered |
| in_data | input | 8 | Byte to send, bit 7 first |
| in_last | input | 1 | This byte closes the packet |
| in_void | input | 1 | When idle: empty packet, nothing is sent |
| in_ready | output | 1 | The offered beat is taken at this clock edge |
| line_oe | output | 1 | 1 pulls the wire low, 0 releases it |
| busy | output | 1 | A packet is on the wire |
| done | output | 1 | One-cycle pulse when a packet (or void request) completes |

## Verification
The first low pulse and `busy` both appear one cycle after the accepting edge. `done` falls in the same cycle that the stop bit releases the line, and a void request raises `done` one cycle after acceptance. The bench drives all inputs on falling edges and samples at the next falling edge, so each of these results is read exactly one cycle after its cause. Pulse lengths are measured in whole cycles by a monitor that samples `line_oe` on every falling edge and logs each low and high run. The log is then compared with lengths worked out from the bit values and the timing mode latched at packet start. For the in-packet handshake the bench counts cycles from the first accept to land its probes inside a chosen bit.

// File: rtl/pwtx_pkg.sv
// Package: shared types for the single-wire pulse-width transmitter.
// Assumes nothing beyond IEEE 1800-2017.
package pwtx_pkg;

    // Transmit sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_STOP = 2'd3
    } pw_state_t;

endpackage

// File: rtl/pwtx_timing.sv
// Module: pwtx_timing
// Turns a bit value and the timing-mode flag into counter load values
// (phase length minus one) for the low phase, the released phase and the
// stop pulse. Purely combinational. Assumes every length is >= 1 and
// fits in CW bits.
module pwtx_timing #(
    parameter int SHORT_CYC     = 16,
    parameter int LONG_CYC      = 48,
    parameter int SLOW_LOW_CYC  = 64,
    parameter int SLOW_HIGH_CYC = 24,
    parameter int STOP_CYC      = 16,
    parameter int CW            = 6
) (
    input  logic          bit_val,
    input  logic          slow,
    output logic [CW-1:0] low_ld,
    output logic [CW-1:0] high_ld,
    output logic [CW-1:0] stop_ld
);
    localparam logic [CW-1:0] L_SHORT = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] L_LONG  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] L_SLOWL = CW'(SLOW_LOW_CYC - 1);
    localparam logic [CW-1:0] L_SLOWH = CW'(SLOW_HIGH_CYC - 1);
    localparam logic [CW-1:0] L_STOP  = CW'(STOP_CYC - 1);

    // Pick phase lengths: a one is short/long in both modes, a zero varies.
    always_comb begin
        if (bit_val) begin
            low_ld  = L_SHORT;
            high_ld = L_LONG;
        end else if (slow) begin
            low_ld  = L_SLOWL;
            high_ld = L_SLOWH;
        end else begin
            low_ld  = L_LONG;
            high_ld = L_SHORT;
        end
        stop_ld = L_STOP;
    end
endmodule

// File: rtl/pwtx_phase_timer.sv
// Module: pwtx_phase_timer
// Down-counter timing one line phase. A load sets the count; it then
// falls by one per cycle and rests at zero. `zero` marks the final cycle
// of the phase. Assumes load is asserted in the cycle a phase ends.
module pwtx_phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Count down from the loaded value, holding at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5: without a load the phase counter steps down by exactly one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pulse_wire_tx.sv
// Module: pulse_wire_tx
// Serialises bytes onto an open-drain wire as pulse-width coded bits,
// bit 7 first, then a stop pulse. `line_oe`=1 pulls the wire low.
// Keeps one byte in reserve so consecutive bytes run without a gap.
// Assumes a 16 MHz clock for the default phase lengths and an external
// pull-up on the wire.
module pulse_wire_tx
    import pwtx_pkg::*;
#(
    parameter int SHORT_CYC     = 16,
    parameter int LONG_CYC      = 48,
    parameter int SLOW_LOW_CYC  = 64,
    parameter int SLOW_HIGH_CYC = 24,
    parameter int STOP_CYC      = 16,
    parameter int DW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_mode,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic          in_void,
    output logic          in_ready,
    output logic          line_oe,
    output logic          busy,
    output logic          done
);
    localparam int MAX_A = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int MAX_B = (SLOW_LOW_CYC > SLOW_HIGH_CYC) ? SLOW_LOW_CYC : SLOW_HIGH_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC  = (MAX_C > STOP_CYC) ? MAX_C : STOP_CYC;
    localparam int CW    = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam int IW    = $clog2(DW);
    localparam logic [IW-1:0] TOP_IDX = IW'(DW - 1);

    pw_state_t     state;
    logic [DW-1:0] cur_q, pend_q;
    logic          cur_last_q, pend_last_q, pend_v_q, slow_q;
    logic [IW-1:0] idx_q;

    logic          t_bit, t_slow, cnt_load, ph_zero;
    logic [CW-1:0] low_ld, high_ld, stop_ld, cnt_val;
    logic          start, void_ack, to_high, bit_next, to_stop, finish, take_pend;

    // Phase-end events derived from the current state and timer.
    always_comb begin
        start     = (state == ST_IDLE) && in_valid && !in_void;
        void_ack  = (state == ST_IDLE) && in_valid && in_void;
        to_high   = (state == ST_LOW) && ph_zero;
        bit_next  = (state == ST_HIGH) && ph_zero && ((idx_q != '0) || pend_v_q);
        to_stop   = (state == ST_HIGH) && ph_zero && (idx_q == '0) && !pend_v_q && cur_last_q;
        finish    = (state == ST_STOP) && ph_zero;
        take_pend = in_ready && in_valid && (state != ST_IDLE);
    end

    // Ready in idle, or during a non-final byte's last bit with no reserve.
    always_comb begin
        in_ready = (state == ST_IDLE) ||
                   (((state == ST_LOW) || (state == ST_HIGH)) &&
                    (idx_q == '0) && !pend_v_q && !cur_last_q);
    end

    // Choose which bit and mode the timing lookup describes.
    always_comb begin
        t_slow = (state == ST_IDLE) ? slow_mode : slow_q;
        case (state)
            ST_IDLE: t_bit = in_data[DW-1];
            ST_LOW:  t_bit = cur_q[idx_q];
            ST_HIGH: t_bit = (idx_q == '0) ? pend_q[DW-1] : cur_q[idx_q - 1'b1];
            default: t_bit = 1'b0;
        endcase
    end

    // Timer reload value for whichever phase begins next.
    always_comb begin
        cnt_load = start || bit_next || to_high || to_stop;
        if (to_high)      cnt_val = high_ld;
        else if (to_stop) cnt_val = stop_ld;
        else              cnt_val = low_ld;
    end

    pwtx_timing #(
        .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC),
        .SLOW_LOW_CYC(SLOW_LOW_CYC), .SLOW_HIGH_CYC(SLOW_HIGH_CYC),
        .STOP_CYC(STOP_CYC), .CW(CW)
    ) u_timing (
        .bit_val(t_bit), .slow(t_slow),
        .low_ld(low_ld), .high_ld(high_ld), .stop_ld(stop_ld)
    );

    pwtx_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(ph_zero)
    );

    // Sequencer: state, line enable and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            line_oe <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= finish || void_ack;
            if (start) begin
                state   <= ST_LOW;
                line_oe <= 1'b1;
            end else if (to_high) begin
                state   <= ST_HIGH;
                line_oe <= 1'b0;
            end else if (bit_next) begin
                state   <= ST_LOW;
                line_oe <= 1'b1;
            end else if (to_stop) begin
                state   <= ST_STOP;
                line_oe <= 1'b1;
            end else if (finish) begin
                state   <= ST_IDLE;
                line_oe <= 1'b0;
            end
        end
    end

    // Byte shift position, current byte and reserve byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_last_q  <= 1'b0;
            pend_q      <= '0;
            pend_last_q <= 1'b0;
            pend_v_q    <= 1'b0;
            idx_q       <= '0;
            slow_q      <= 1'b0;
        end else begin
            if (start) begin
                cur_q      <= in_data;
                cur_last_q <= in_last;
                idx_q      <= TOP_IDX;
                slow_q     <= slow_mode;
            end else if (bit_next) begin
                if (idx_q != '0) begin
                    idx_q <= idx_q - 1'b1;
                end else begin
                    cur_q      <= pend_q;
                    cur_last_q <= pend_last_q;
                    idx_q      <= TOP_IDX;
                    pend_v_q   <= 1'b0;
                end
            end
            if (take_pend) begin
                pend_q      <= in_data;
                pend_last_q <= in_last;
                pend_v_q    <= 1'b1;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: when done is high the line is released and no packet is active
    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!line_oe && !busy));
    // R6: the wire is pulled low only inside a packet
    p_oe_in_packet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> busy);
    // R9: mid-packet acceptance only during a byte's final bit
    p_ready_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && busy) |-> (idx_q == '0));
    // R10: an accepted void request never pulls the wire
    p_void_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        void_ack |=> (!line_oe && !busy));
    // R11: latched timing mode stays fixed while a packet runs
    p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(slow_q));
endmodule

// File: tb/pulse_wire_tx_bench.sv
module pulse_wire_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_void = 1'b0;
    logic       in_ready, line_oe, busy, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pulse_wire_tx u_pulse_wire_tx (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_void(in_void), .in_ready(in_ready), .line_oe(line_oe),
        .busy(busy), .done(done)
    );

    // Stimulus table: {slow, byte count, byte0, byte1, byte2, byte3}
    localparam int NV = 5;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 3'd1, 8'hA5, 8'h00, 8'h00, 8'h00},
        {1'b0, 3'd2, 8'h00, 8'hFF, 8'h00, 8'h00},
        {1'b1, 3'd1, 8'h5A, 8'h00, 8'h00, 8'h00},
        {1'b1, 3'd3, 8'h80, 8'h01, 8'hC3, 8'h00},
        {1'b0, 3'd4, 8'h12, 8'h34, 8'hE7, 8'h6D}
    };

    // Line monitor: run lengths of low (oe=1) and high (oe=0) periods.
    int  lows [64];
    int  highs[64];
    int  nlow = 0, nhigh = 0, ndone = 0, done_bad = 0, run = 0;
    bit  prev_oe = 1'b0, in_pkt = 1'b0;

    always @(negedge clk) begin
        if (line_oe != prev_oe) begin
            if (prev_oe) begin
                if (nlow < 64) lows[nlow] = run;
                nlow++;
            end else if (in_pkt) begin
                if (nhigh < 64) highs[nhigh] = run;
                nhigh++;
            end
            if (line_oe) in_pkt = 1'b1;
            run = 1;
        end else begin
            run++;
        end
        if (done) begin
            ndone++;
            if (!(prev_oe && !line_oe) || busy) done_bad++;
            in_pkt = 1'b0;
        end
        prev_oe = line_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nlow = 0; nhigh = 0; ndone = 0; done_bad = 0;
    endtask

    function automatic int exp_low(bit b, bit s);
        return b ? 16 : (s ? 64 : 48);
    endfunction

    function automatic int exp_high(bit b, bit s);
        return b ? 48 : (s ? 24 : 16);
    endfunction

    // Compare logged runs with those expected from bytes and mode.
    task automatic check_runs(input bit s, input int n, input logic [31:0] bytes);
        int bad = 0;
        check(nlow == 8*n + 1, "R7 low pulse count", nlow, 8*n + 1);
        check(nhigh == 8*n, "R5 high period count", nhigh, 8*n);
        for (int k = 0; k < 8*n && k < 63; k++) begin
            bit b = bytes[31 - k];
            string tag = b ? "R3" : (s ? "R4" : "R2");
            if (lows[k] != exp_low(b, s) || highs[k] != exp_high(b, s)) bad++;
            check(lows[k] == exp_low(b, s), {tag, " low length"}, lows[k], exp_low(b, s));
            check(highs[k] == exp_high(b, s), {tag, " high length"}, highs[k], exp_high(b, s));
        end
        check(bad == 0, "R5 R11 bit order and latched timing", bad, 0);
        check(lows[8*n] == 16, "R7 stop pulse length", lows[8*n], 16);
        check(ndone == 1, "R8 done pulse count", ndone, 1);
        check(done_bad == 0, "R8 done aligned with release", done_bad, 0);
    endtask

    // Offer one byte and return at the falling edge after it is taken.
    task automatic push(input logic [7:0] d, input bit last);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        in_void  = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_done();
        int guard = 0;
        while (ndone == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        check(!line_oe && !busy && !done && in_ready, "R1 state in reset",
              {line_oe, busy, done, in_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!line_oe && !busy && !done && in_ready, "R1 state after reset",
              {line_oe, busy, done, in_ready}, 4'b0001);

        // Table walk: each packet flips slow_mode after the first accept (R11)
        for (int v = 0; v < NV; v++) begin
            bit          s  = VEC[v][35];
            int          n  = int'(VEC[v][34:32]);
            logic [31:0] bs = VEC[v][31:0];
            clear_mon();
            slow_mode = s;
            for (int i = 0; i < n; i++) begin
                push(bs[31 - 8*i -: 8], i == n - 1);
                if (i == 0) slow_mode = ~s;
            end
            in_valid = 1'b0;
            wait_done();
            check_runs(s, n, bs);
        end

        // R6: latency of the first pull-low; R9: ready closed for a last byte
        clear_mon();
        slow_mode = 1'b0;
        push(8'hFF, 1'b1);
        in_valid = 1'b0;
        check(line_oe && busy, "R6 oe and busy one cycle after accept",
              {line_oe, busy}, 2'b11);
        repeat (20) @(negedge clk);
        check(!in_ready, "R9 ready low inside first bit", in_ready, 0);
        repeat (7*64) @(negedge clk);
        check(!in_ready, "R9 ready low in last bit of last byte", in_ready, 0);
        wait_done();
        check_runs(1'b0, 1, 32'hFF00_0000);

        // R9: second byte offered only once ready opens in the last bit
        clear_mon();
        slow_mode = 1'b0;
        push(8'h00, 1'b0);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(!in_ready, "R9 ready low early in byte", in_ready, 0);
        repeat (7*64 + 10 - 5) @(negedge clk);
        check(in_ready, "R9 ready high in final bit", in_ready, 1);
        push(8'hFF, 1'b1);
        in_valid = 1'b0;
        wait_done();
        check_runs(1'b0, 2, 32'h00FF_0000);

        // R10: void request sends nothing and pulses done
        clear_mon();
        in_valid = 1'b1;
        in_void  = 1'b1;
        in_last  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_void  = 1'b0;
        check(done && !busy && !line_oe, "R10 done after void accept",
              {done, busy, line_oe}, 3'b100);
        @(negedge clk);
        check(!done, "R10 done lasts one cycle", done, 0);
        repeat (40) @(negedge clk);
        check(nlow == 0 && !busy, "R10 no low pulse for void", nlow, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule